// File: doc/BRIEF.md
# Bus-Hold Block Transfer Controller

This block is a single-channel direct memory access engine. It moves a block of words between one peripheral and memory without the processor taking part. Before a block starts, the processor programs four registers through a small write port: a start address, a word count, and a control word that holds the direction, the bus-occupancy mode and a start bit. A fourth register clears the completion interrupt.

When the peripheral raises its request, the controller asks the processor for the bus with a hold signal. It touches neither the memory port nor the peripheral acknowledge until the processor answers with hold-acknowledge. Once it owns the bus, it drives one address and one strobe per word on a synchronous memory master port. After each word the address goes up by one and the remaining count goes down by one. Three occupancy modes decide when the bus is handed back:
- burst keeps the bus for the whole block;
- cycle steal hands it back after every word;
- transparent moves a word only in cycles where the processor reports that it is not using the bus.

When the count reaches zero, the controller releases the bus and raises an interrupt. The interrupt stays high until the processor clears it.

Top module: `dma_hold_ctrl`

## Requirements
- R1: While reset is high and after reset, `hold`, `dack`, `mem_we`, `mem_re`, `per_rvalid` and `irq` are low.
- R2: A raised `dreq` on an active block makes `hold` rise. `dack` rises only when `hlda` was high at the clock edge that raises it. Every memory strobe cycle has `hold` and `dack` high, and `hlda` was high at the edge that issued the strobe.
- R3: The processor writes registers with `cfg_we` and `cfg_sel`:
  - select 0 loads the start address from `cfg_wdata[AW-1:0]`;
  - select 1 loads the word count from `cfg_wdata[CW-1:0]`;
  - select 2 is the control word: bit 0 is the direction, bits 2:1 are the mode, and a 1 in bit 3 starts the block;
  - select 3 is the clear register.

  A block of N words produces exactly N strobe cycles, at addresses start, start+1, …, which wrap modulo 2^AW.
- R4: Direction 0 moves data from the peripheral to memory. Each strobe is a `mem_we` cycle, and `mem_wdata` equals the `per_wdata` value present at the issuing edge. Direction 1 moves data from memory to the peripheral. Each strobe is a `mem_re` cycle. Memory returns the data in the next cycle, and the cycle after that `per_rvalid` is high with that word on `per_rdata`. `mem_we` and `mem_re` are never both high.
- R5: In burst mode (mode 00), `hold` rises once per block and stays high until the last word, even when `dreq` drops in the middle of the block. No word moves while `dreq` is low.
- R6: In cycle-steal mode (mode 01), `hold` and `dack` drop in the cycle after each strobe cycle. If `dreq` is low while the controller owns the bus without moving a word, it releases `hold` and `dack` in the next cycle.
- R7: In transparent mode (mode 10), the controller raises `hold` and issues a word only at edges where `cpu_idle` is high. It releases the bus when `cpu_idle` or `dreq` goes low. In the other modes `cpu_idle` has no effect.
- R8: The cycle after the last strobe cycle, `irq` rises, and in that cycle `hold` is low.
- R9: `irq` stays high until a write to select 3 with bit 0 set. That write clears `irq` at its clock edge. A write to select 3 with bit 0 clear leaves `irq` unchanged.
- R10: Starting a block with a word count of 0 raises `irq` at the start edge. No `hold` and no strobe follow.
- R11: No strobe is issued at an edge where `dreq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe from the processor |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control, 3 clear |
| cfg_wdata | input | REG_W | Register write data |
| dreq | input | 1 | Service request from the peripheral |
| dack | output | 1 | Acknowledge to the peripheral while the controller owns the bus |
| per_wdata | input | DW | Word offered by the peripheral (peripheral-to-memory direction) |
| per_rdata | output | DW | Word delivered to the peripheral (memory-to-peripheral direction) |
| per_rvalid | output | 1 | One-cycle pulse marking a new word on `per_rdata` |
| hold | output | 1 | Bus request to the processor |
| hlda | input | 1 | Processor has released the bus |
| cpu_idle | input | 1 | Processor is not using the bus in this cycle (transparent mode) |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe; data returns one cycle later |
| mem_rdata | input | DW | Memory read data |
| irq | output | 1 | Block-complete interrupt, held until cleared |

## Verification
The bench delays hold-acknowledge by a random number of cycles. A controller that drove the bus early would show a strobe or an acknowledge without a preceding `hlda`. The peripheral drops its request at random. A burst engine that let go of the bus would show more than one hold rise, and a cycle-steal engine that kept the bus would show `dack` high across an idle request. Random `cpu_idle` in transparent mode exposes a strobe issued while the processor was busy. A block placed near the top of the address space catches an address that does not wrap. A zero-count start catches an engine that requests the bus for nothing. The clear tests, with bit 0 set and with bit 0 clear, catch an interrupt that drops on its own or on the wrong write.

// File: rtl/dma_hold_pkg.sv
`timescale 1ns/1ps
package dma_hold_pkg;
  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;
  localparam logic [1:0] SEL_CLEAR = 2'd3;

  localparam int CTRL_DIR  = 0;
  localparam int CTRL_MODE = 1;
  localparam int CTRL_GO   = 3;
  localparam int CTRL_W    = 4;

  localparam logic [1:0] MODE_BURST = 2'd0;
  localparam logic [1:0] MODE_STEAL = 2'd1;
  localparam logic [1:0] MODE_GLIDE = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ASK  = 2'd1,
    ST_OWN  = 2'd2,
    ST_TAIL = 2'd3
  } seq_state_t;
endpackage

// File: rtl/dma_cfg_regs.sv
`timescale 1ns/1ps
module dma_cfg_regs
  import dma_hold_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CTRL_W-1:0] cfg_ctrl,
  input  logic              done_set,
  output logic              load_addr,
  output logic              load_cnt,
  output logic              go,
  output logic              dir_q,
  output logic [1:0]        mode_q,
  output logic              irq_q
);
  logic clear_wr;

  assign load_addr = cfg_we && (cfg_sel == SEL_ADDR);
  assign load_cnt  = cfg_we && (cfg_sel == SEL_COUNT);
  assign go        = cfg_we && (cfg_sel == SEL_CTRL) && cfg_ctrl[CTRL_GO];
  assign clear_wr  = cfg_we && (cfg_sel == SEL_CLEAR) && cfg_ctrl[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= 1'b0;
      mode_q <= MODE_BURST;
      irq_q  <= 1'b0;
    end else begin
      if (cfg_we && (cfg_sel == SEL_CTRL)) begin
        dir_q  <= cfg_ctrl[CTRL_DIR];
        mode_q <= cfg_ctrl[CTRL_MODE +: 2];
      end
      if (done_set)
        irq_q <= 1'b1;
      else if (clear_wr)
        irq_q <= 1'b0;
    end
  end

  // R9: the interrupt only falls on a clear write
  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !(cfg_we && cfg_sel == SEL_CLEAR && cfg_ctrl[0])) |=> irq_q);
endmodule

// File: rtl/dma_walker.sv
`timescale 1ns/1ps
module dma_walker #(
  parameter int AW = 16,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_addr,
  input  logic          load_cnt,
  input  logic [AW-1:0] addr_in,
  input  logic [CW-1:0] cnt_in,
  input  logic          step,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] cnt_q,
  output logic          cnt_zero,
  output logic          cnt_last
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (load_addr)
        addr_q <= addr_in;
      else if (step)
        addr_q <= addr_q + 1'b1;
      if (load_cnt)
        cnt_q <= cnt_in;
      else if (step)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_zero = (cnt_q == '0);
  assign cnt_last = (cnt_q == CNT_ONE);

  // R3: one word per step, the address walks up, the count walks down
  assert_walk_step_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !load_addr && !load_cnt) |=>
      (addr_q == AW'($past(addr_q) + 1'b1)) && (cnt_q == CW'($past(cnt_q) - 1'b1)));
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    step |-> !cnt_zero);
endmodule

// File: rtl/dma_bus_seq.sv
`timescale 1ns/1ps
module dma_bus_seq
  import dma_hold_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          dir,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] addr_q,
  input  logic          cnt_zero,
  input  logic          cnt_last,
  input  logic          dreq,
  input  logic          hlda,
  input  logic          cpu_idle,
  input  logic [DW-1:0] per_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          step,
  output logic          done,
  output logic          hold,
  output logic          dack,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] per_rdata,
  output logic          per_rvalid
);
  seq_state_t st_q, st_d;
  logic active_q;
  logic rd_pend_q;
  logic steal, glide, bus_ok, go_word;

  assign steal   = (mode == MODE_STEAL);
  assign glide   = (mode == MODE_GLIDE);
  assign bus_ok  = !glide || cpu_idle;
  assign go_word = (st_q == ST_OWN) && dreq && hlda && bus_ok && !cnt_zero;
  assign step    = go_word;
  assign done    = (go && cnt_zero) || ((st_q == ST_TAIL) && cnt_zero);
  assign hold    = (st_q != ST_IDLE);
  assign dack    = (st_q == ST_OWN) || (st_q == ST_TAIL);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (active_q && !cnt_zero && dreq && bus_ok) st_d = ST_ASK;
      ST_ASK:  if (hlda) st_d = ST_OWN;
      ST_OWN: begin
        if (go_word) begin
          if (cnt_last || steal) st_d = ST_TAIL;
        end else if ((steal || glide) && !dreq) begin
          st_d = ST_IDLE;
        end else if (glide && !cpu_idle) begin
          st_d = ST_IDLE;
        end
      end
      ST_TAIL: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      active_q   <= 1'b0;
      mem_we     <= 1'b0;
      mem_re     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      rd_pend_q  <= 1'b0;
      per_rvalid <= 1'b0;
      per_rdata  <= '0;
    end else begin
      st_q <= st_d;
      if (go && !cnt_zero)
        active_q <= 1'b1;
      else if ((st_q == ST_TAIL) && cnt_zero)
        active_q <= 1'b0;
      mem_we <= go_word && !dir;
      mem_re <= go_word && dir;
      if (go_word) begin
        mem_addr  <= addr_q;
        mem_wdata <= per_wdata;
      end
      rd_pend_q  <= mem_re;
      per_rvalid <= rd_pend_q;
      if (rd_pend_q)
        per_rdata <= mem_rdata;
    end
  end

  // R2: the bus is driven only after the processor let go of it
  assert_strobe_owned_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) |-> (hold && dack && $past(hlda)));
  assert_dack_after_hlda_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(dack) |-> $past(hlda));
  // R4: one direction per cycle
  assert_one_dir_R4: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));
  // R6: cycle steal hands the bus back after each word
  assert_steal_release_R6: assert property (@(posedge clk) disable iff (rst)
    ((mem_we || mem_re) && steal) |=> !dack);
  // R7: transparent words only in processor-idle cycles
  assert_glide_idle_R7: assert property (@(posedge clk) disable iff (rst)
    ((mem_we || mem_re) && glide) |-> $past(cpu_idle));
  // R11: no word without a request
  assert_need_dreq_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) |-> $past(dreq));
endmodule

// File: rtl/dma_hold_ctrl.sv
`timescale 1ns/1ps
module dma_hold_ctrl
  import dma_hold_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 10,
  parameter int DW    = 16,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             dreq,
  output logic             dack,
  input  logic [DW-1:0]    per_wdata,
  output logic [DW-1:0]    per_rdata,
  output logic             per_rvalid,
  output logic             hold,
  input  logic             hlda,
  input  logic             cpu_idle,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             mem_we,
  output logic             mem_re,
  input  logic [DW-1:0]    mem_rdata,
  output logic             irq
);
  logic          load_addr, load_cnt, go, dir_q, done, step;
  logic [1:0]    mode_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          cnt_zero, cnt_last;

  dma_cfg_regs u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_ctrl(cfg_wdata[CTRL_W-1:0]), .done_set(done),
    .load_addr(load_addr), .load_cnt(load_cnt), .go(go),
    .dir_q(dir_q), .mode_q(mode_q), .irq_q(irq)
  );

  dma_walker #(.AW(AW), .CW(CW)) u_walk (
    .clk(clk), .rst(rst), .load_addr(load_addr), .load_cnt(load_cnt),
    .addr_in(cfg_wdata[AW-1:0]), .cnt_in(cfg_wdata[CW-1:0]), .step(step),
    .addr_q(addr_q), .cnt_q(cnt_q), .cnt_zero(cnt_zero), .cnt_last(cnt_last)
  );

  dma_bus_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst), .go(go), .dir(dir_q), .mode(mode_q),
    .addr_q(addr_q), .cnt_zero(cnt_zero), .cnt_last(cnt_last),
    .dreq(dreq), .hlda(hlda), .cpu_idle(cpu_idle), .per_wdata(per_wdata),
    .mem_rdata(mem_rdata), .step(step), .done(done), .hold(hold), .dack(dack),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .per_rdata(per_rdata), .per_rvalid(per_rvalid)
  );

  // R8: the interrupt appears with the bus already returned
  assert_irq_bus_free_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> !hold);
  // R10: an empty block completes at once
  assert_zero_count_R10: assert property (@(posedge clk) disable iff (rst)
    (go && cnt_zero) |=> (irq && !hold));
endmodule

// File: tb/test_dma_hold_ctrl.sv
`timescale 1ns/1ps
module test_dma_hold_ctrl;
  localparam int AW = 8;
  localparam int CW = 8;
  localparam int DW = 16;
  localparam int RW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [RW-1:0] cfg_wdata = '0;
  logic          dreq = 1'b0, hlda = 1'b0, cpu_idle = 1'b1;
  logic [DW-1:0] per_wdata = '0;
  logic [DW-1:0] mem_rdata = '0;
  logic          dack, per_rvalid, hold, mem_we, mem_re, irq;
  logic [DW-1:0] per_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;

  int n_cmp = 0;
  int n_bad = 0;

  dma_hold_ctrl #(.AW(AW), .CW(CW), .DW(DW), .REG_W(RW)) i_dma_hold_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .dreq(dreq), .dack(dack), .per_wdata(per_wdata), .per_rdata(per_rdata),
    .per_rvalid(per_rvalid), .hold(hold), .hlda(hlda), .cpu_idle(cpu_idle),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .irq(irq)
  );

  logic [DW-1:0] mem [0:255];
  initial for (int i = 0; i < 256; i++) mem[i] = DW'(i * 3 + 7);
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  function automatic logic [DW-1:0] pat(input int blk, input int i);
    return DW'(blk * 37 + i * 101 + 5) ^ 16'hA5C3;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input int val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = RW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_block(input int blk, input int start, input int cnt, input bit dir,
                           input int mode, input int dreq_pct, input int idle_pct, input int dly);
    int k, rx, rises, wcnt, cyc, post;
    bit pdreq, phlda, pidle, phold, pdack, pstrobe, seen, strobe, wr_ok;
    cfg_write(2'd0, start);
    cfg_write(2'd1, cnt);
    cfg_write(2'd2, 8 | (mode << 1) | int'(dir));
    k = 0; rx = 0; rises = 0; wcnt = 0; cyc = 0; post = 0;
    pdreq = dreq; phlda = hlda; pidle = cpu_idle;
    phold = 1'b0; pdack = 1'b0; pstrobe = 1'b0; seen = 1'b0;
    while (post < 3) begin
      @(negedge clk);
      cyc++;
      if (cyc > 3000) begin
        check(1'b0, "R8 block watchdog", cyc, 3000);
        break;
      end
      strobe = mem_we | mem_re;
      if (strobe) begin
        check(hold && dack && phlda, "R2 strobe without bus grant", int'(phlda), 1);
        check(pdreq, "R11 strobe without request", int'(pdreq), 1);
        if (mode == 2) check(pidle, "R7 strobe while processor busy", int'(pidle), 1);
        check(int'(mem_addr) == ((start + k) & 255), "R3 address", int'(mem_addr), (start + k) & 255);
        check(dir ? (mem_re && !mem_we) : (mem_we && !mem_re), "R4 strobe kind", int'(mem_we), int'(!dir));
        if (!dir) check(mem_wdata == pat(blk, k), "R4 write data", int'(mem_wdata), int'(pat(blk, k)));
        k++;
      end
      if (per_rvalid) begin
        check(per_rdata == mem[(start + rx) & 255], "R4 read data", int'(per_rdata),
              int'(mem[(start + rx) & 255]));
        rx++;
      end
      if (hold && !phold) begin
        rises++;
        if (mode == 2) check(pidle, "R7 hold raised while processor busy", int'(pidle), 1);
      end
      if (dack && !pdack) check(phlda, "R2 dack before hlda", int'(phlda), 1);
      if (mode == 1 && dack && pdack && (!pdreq || pstrobe))
        check(1'b0, "R6 bus kept after word or lost request", 1, 0);
      if (irq && !seen) begin
        seen = 1'b1;
        check(!hold, "R8 hold low at interrupt", int'(hold), 0);
        check(k == cnt, "R8 words before interrupt", k, cnt);
        if (cnt > 0) check(pstrobe, "R8 interrupt right after last word", int'(pstrobe), 1);
        else check(cyc <= 1, "R10 zero count interrupt delay", cyc, 1);
      end
      if (seen) post++;
      dreq = (k < cnt) && ($urandom_range(99) < dreq_pct);
      if (hold) begin
        wcnt++;
        hlda = (wcnt > dly);
      end else begin
        wcnt = 0;
        hlda = 1'b0;
      end
      cpu_idle = (mode == 2) ? ($urandom_range(99) < idle_pct) : ($urandom_range(1) == 0);
      per_wdata = pat(blk, k);
      pdreq = dreq; phlda = hlda; pidle = cpu_idle;
      phold = hold; pdack = dack; pstrobe = strobe;
    end
    dreq = 1'b0;
    check(k == cnt, "R3 word count", k, cnt);
    if (dir) check(rx == cnt, "R4 words delivered", rx, cnt);
    else begin
      wr_ok = 1'b1;
      for (int i = 0; i < cnt; i++) if (mem[(start + i) & 255] != pat(blk, i)) wr_ok = 1'b0;
      check(wr_ok, "R4 memory contents", int'(wr_ok), 1);
    end
    if (cnt == 0) check(rises == 0, "R10 no hold on zero count", rises, 0);
    else if (mode == 0) check(rises == 1, "R5 single hold per burst", rises, 1);
    else if (mode == 1) begin
      if (dreq_pct >= 100) check(rises == cnt, "R6 hold per word", rises, cnt);
      else check(rises >= cnt, "R6 hold per word", rises, cnt);
    end
    check(irq, "R9 interrupt held", int'(irq), 1);
    cfg_write(2'd3, 0);
    check(irq, "R9 clear without bit0", int'(irq), 1);
    cfg_write(2'd3, 1);
    check(!irq, "R9 clear with bit0", int'(irq), 0);
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "R1 global watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (2) @(negedge clk);
    check(!hold && !dack && !mem_we && !mem_re && !irq && !per_rvalid, "R1 outputs in reset",
          int'({hold, dack, mem_we, mem_re, irq}), 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!hold && !dack && !mem_we && !mem_re && !irq && !per_rvalid, "R1 outputs after reset",
          int'({hold, dack, mem_we, mem_re, irq}), 0);
    run_block(0, 16, 8, 1'b0, 0, 100, 100, 3);
    run_block(1, 16, 8, 1'b1, 0, 100, 100, 0);
    run_block(2, 40, 6, 1'b0, 1, 100, 100, 1);
    run_block(3, 40, 6, 1'b1, 1, 50, 100, 2);
    run_block(4, 80, 10, 1'b0, 2, 100, 40, 0);
    run_block(5, 80, 10, 1'b1, 2, 80, 50, 1);
    run_block(6, 100, 0, 1'b0, 0, 100, 100, 0);
    run_block(7, 250, 12, 1'b0, 0, 100, 100, 2);
    run_block(8, 120, 14, 1'b0, 0, 60, 100, 1);
    run_block(9, 130, 9, 1'b0, 1, 50, 100, 0);
    for (int b = 10; b < 36; b++)
      run_block(b, $urandom_range(255), $urandom_range(16), 1'($urandom_range(1)),
                $urandom_range(2), $urandom_range(100, 40), $urandom_range(100, 30),
                $urandom_range(3));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule